// File: doc/BRIEF.md
# Register-Controlled Watchdog Timer

A watchdog timer that sits on a simple peripheral bus. Software programs a 32-bit time-out constant, sets the enable bit and then feeds the watchdog with a two-write key sequence. Each valid feed reloads a down counter from the constant. The counter steps down once every four clocks. If software stops feeding, the counter runs out. The block then raises an interrupt and, when reset-enable is set, sends a one-cycle reset request to the chip's reset generator.

The bus uses word offsets on `addr_i`: 0 is mode, 1 is the time-out constant, 2 is the feed register and 3 is the current count. Reads are combinational, so `rdata_o` is valid in the same cycle as the access. The reset generator answers a request by pulsing `wdt_rst_i`. That input clears the whole block except the time-out flag, so software can tell after reboot that the watchdog caused the reset.

Top module: `wdt_top`

## Requirements
- R1: After `rst_ni`, the mode register reads 0, the constant reads 0xFF, the count reads 0xFF, and `irq_o` and `rst_req_o` are low.
- R2: The mode register has four bits: bit0 enable, bit1 reset-enable, bit2 time-out flag, bit3 interrupt flag. Bits 31:4 read as zero. Mode writes OR data bits 0 and 1 into enable and reset-enable, so software can set these bits but never clear them.
- R3: A mode write with data bit2 = 0 clears the time-out flag. Mode writes do not change the interrupt flag, and `irq_o` always equals that flag.
- R4: A time-out happens on the prescaler tick that finds the count at 0. It sets the time-out and interrupt flags, clears enable and reset-enable, and stops the counter at 0. The interval from feed to flags is 4*(K+1) clocks.
- R5: A constant write of a value below 0xFF stores 0xFF. Any other value is stored unchanged.
- R6: A valid feed is a write of 0xAA to the feed register, where the next bus access is a write of 0x55 to the feed register. The 0x55 write reloads the count from the constant in that cycle. Any other access in between cancels the feed.
- R7: When enable is set, the counter stays idle until the first valid feed. A feed while enable is 0 reloads nothing.
- R8: While running, the count drops by one on every fourth clock after a feed. The first drop comes 4 clocks after the reload.
- R9: `rst_req_o` is a one-cycle pulse in the cycle after a time-out, but only when reset-enable was set. There is no pulse when reset-enable is clear.
- R10: `wdt_rst_i` clears enable, reset-enable, the interrupt flag, the feed state and the counter state. It also returns the constant and the count to 0xFF. The time-out flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Active-low asynchronous external reset |
| wdt_rst_i | input | 1 | Synchronous reset caused by the watchdog |
| req_i | input | 1 | Bus access valid |
| we_i | input | 1 | Write (1) or read (0) |
| addr_i | input | 2 | Register word offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| irq_o | output | 1 | Interrupt flag |
| rst_req_o | output | 1 | One-cycle chip reset request |

## Verification
Read data is due in the same cycle as the read access. The monitor therefore compares each queued expectation at the falling edge of that cycle. A register write becomes visible at the first access after the write's sampling edge. The count is still K in the two cycles after a feed, and it first reads K-1 after the fourth edge. The flags and the reset request change on edge 4*(K+1) after the feed. The bench counts idle edges from the feed so that it samples at edge 4*(K+1)-1 and edge 4*(K+1), and at the edge after that to see the request fall.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    REG_MODE  = 2'd0,
    REG_CONST = 2'd1,
    REG_FEED  = 2'd2,
    REG_COUNT = 2'd3
  } reg_sel_e;

  localparam logic [7:0] FEED_KEY_A = 8'hAA;
  localparam logic [7:0] FEED_KEY_B = 8'h55;

  localparam int unsigned MODE_EN   = 0;
  localparam int unsigned MODE_RSTEN = 1;
  localparam int unsigned MODE_TOF  = 2;
  localparam int unsigned MODE_INT  = 3;
endpackage

// File: rtl/wdt_feed_seq.sv
module wdt_feed_seq
  import wdt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       acc_i,
  input  logic       key_wr_i,
  input  logic [7:0] key_i,
  output logic       feed_o
);
  logic armed_q;

  // every access re-evaluates: only a first-key write leaves the sequence armed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     armed_q <= 1'b0;
    else if (clr_i)  armed_q <= 1'b0;
    else if (acc_i)  armed_q <= key_wr_i && (key_i == FEED_KEY_A);
  end

  assign feed_o = acc_i & key_wr_i & armed_q & ~clr_i & (key_i == FEED_KEY_B);
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  pre_q <= '0;
    else if (restart_i || !run_i) pre_q <= '0;
    else if (pre_q == LAST)       pre_q <= '0;
    else                          pre_q <= pre_q + 1'b1;
  end

  assign tick_o = run_i & ~restart_i & (pre_q == LAST);
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int unsigned       CNT_W = 32,
  parameter logic [CNT_W-1:0]  INIT  = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= INIT;
    else if (clr_i)                  cnt_q <= INIT;
    else if (load_i)                 cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  // underflow: a tick arriving with the count already at zero
  assign expire_o = tick_i & ~load_i & ~clr_i & (cnt_q == '0);
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned PRESCALE  = 4,
  parameter int unsigned CONST_MIN = 255
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wdt_rst_i,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             irq_o,
  output logic             rst_req_o
);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(CONST_MIN);

  reg_sel_e         sel;
  logic             wr_mode, wr_const, wr_feed;
  logic             feed_pulse, feed_ok, tick, expire, timeout;
  logic             en_q, rsten_q, tof_q, int_q, run_q, rst_req_q;
  logic [CNT_W-1:0] const_q, cnt_q;

  assign sel      = reg_sel_e'(addr_i);
  assign wr_mode  = req_i & we_i & (sel == REG_MODE);
  assign wr_const = req_i & we_i & (sel == REG_CONST);
  assign wr_feed  = req_i & we_i & (sel == REG_FEED);

  wdt_feed_seq i_feed (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (wdt_rst_i),
    .acc_i   (req_i),
    .key_wr_i(wr_feed),
    .key_i   (wdata_i[7:0]),
    .feed_o  (feed_pulse)
  );

  assign feed_ok = feed_pulse & en_q;

  wdt_prescale #(.DIV(PRESCALE)) i_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_q),
    .restart_i(feed_ok | wdt_rst_i),
    .tick_o   (tick)
  );

  wdt_count #(.CNT_W(CNT_W), .INIT(MIN_V)) i_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (wdt_rst_i),
    .load_i    (feed_ok),
    .load_val_i(const_q),
    .tick_i    (tick),
    .cnt_o     (cnt_q),
    .expire_o  (expire)
  );

  assign timeout = expire & ~feed_ok;

  // mode bits; tof only cleared by external reset or software
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      rsten_q   <= 1'b0;
      tof_q     <= 1'b0;
      int_q     <= 1'b0;
      run_q     <= 1'b0;
      rst_req_q <= 1'b0;
    end else if (wdt_rst_i) begin
      en_q      <= 1'b0;
      rsten_q   <= 1'b0;
      int_q     <= 1'b0;
      run_q     <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= timeout & rsten_q;
      if (timeout) begin
        en_q    <= 1'b0;
        rsten_q <= 1'b0;
        run_q   <= 1'b0;
        tof_q   <= 1'b1;
        int_q   <= 1'b1;
      end else begin
        if (wr_mode) begin
          en_q    <= en_q    | wdata_i[MODE_EN];
          rsten_q <= rsten_q | wdata_i[MODE_RSTEN];
          if (!wdata_i[MODE_TOF]) tof_q <= 1'b0;
        end
        if (feed_ok) run_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        const_q <= MIN_V;
    else if (wdt_rst_i) const_q <= MIN_V;
    else if (wr_const)  const_q <= (wdata_i < MIN_V) ? MIN_V : wdata_i;
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      unique case (sel)
        REG_MODE: begin
          rdata_o[MODE_EN]    = en_q;
          rdata_o[MODE_RSTEN] = rsten_q;
          rdata_o[MODE_TOF]   = tof_q;
          rdata_o[MODE_INT]   = int_q;
        end
        REG_CONST: rdata_o = const_q;
        REG_COUNT: rdata_o = cnt_q;
        default:   rdata_o = '0;
      endcase
    end
  end

  assign irq_o     = int_q;
  assign rst_req_o = rst_req_q;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned CONST_MIN = 255
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wdt_rst_i,
  input logic             irq_o,
  input logic             rst_req_o,
  input logic             en_q,
  input logic             feed_ok,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] const_q
);
  assert_req_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  assert_req_with_irq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> irq_o);

  assert_en_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_q) |-> ($past(wdt_rst_i) || irq_o));

  assert_irq_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(wdt_rst_i));

  assert_const_floor_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    const_q >= CNT_W'(CONST_MIN));

  assert_count_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != $past(cnt_q)) |->
      ((cnt_q == $past(cnt_q) - 1'b1) || $past(feed_ok) || $past(wdt_rst_i)));
endmodule

bind wdt_top wdt_checker #(.CNT_W(CNT_W), .CONST_MIN(CONST_MIN)) i_wdt_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wdt_rst_i(wdt_rst_i),
  .irq_o    (irq_o),
  .rst_req_o(rst_req_o),
  .en_q     (en_q),
  .feed_ok  (feed_ok),
  .cnt_q    (cnt_q),
  .const_q  (const_q)
);

// File: tb/test_wdt_top.sv
module test_wdt_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wdt_rst_i = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, rst_req_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  localparam logic [1:0] A_MODE = 2'd0, A_CONST = 2'd1, A_FEED = 2'd2, A_CNT = 2'd3;

  always #10 clk_i = ~clk_i;

  wdt_top i_wdt_top (
    .clk_i, .rst_ni, .wdt_rst_i, .req_i, .we_i, .addr_i,
    .wdata_i, .rdata_o, .irq_o, .rst_req_o
  );

  // monitor: compare read data in the access cycle
  always @(negedge clk_i) begin
    if (rst_ni && req_i && !we_i) begin
      if (sb_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL scoreboard empty on read, actual %h", rdata_o);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        n_cmp++;
        if (rdata_o !== e.exp) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", e.tag, rdata_o, e.exp);
        end
      end
    end
  end

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk_i); #2;
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
  endtask

  task automatic bus_rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    exp_t e;
    e.exp = exp; e.tag = tag;
    sb_q.push_back(e);
    @(posedge clk_i); #2;
    req_i = 1'b1; we_i = 1'b0; addr_i = a; wdata_i = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i); #2;
      req_i = 1'b0; we_i = 1'b0;
    end
  endtask

  task automatic check_pin(input logic act, input logic exp, input string tag);
    @(negedge clk_i);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic feed();
    bus_wr(A_FEED, 32'hAA);
    bus_wr(A_FEED, 32'h55);
  endtask

  task automatic ext_reset();
    @(posedge clk_i); #2;
    req_i = 1'b0; we_i = 1'b0; rst_ni = 1'b0;
    repeat (2) @(posedge clk_i);
    #2 rst_ni = 1'b1;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    ext_reset();
    idle(1);
    check_pin(irq_o, 1'b0, "R1 irq");
    check_pin(rst_req_o, 1'b0, "R1 rst_req");
    bus_rd(A_MODE, 32'h0, "R1 mode");
    bus_rd(A_CONST, 32'hFF, "R1 const");
    bus_rd(A_CNT, 32'hFF, "R1 count");

    bus_wr(A_CONST, 32'h10);
    bus_rd(A_CONST, 32'hFF, "R5 clamp low");
    bus_wr(A_CONST, 32'hFE);
    bus_rd(A_CONST, 32'hFF, "R5 clamp edge");
    bus_wr(A_CONST, 32'h1234);
    bus_rd(A_CONST, 32'h1234, "R5 pass");

    bus_wr(A_MODE, 32'h1);
    bus_rd(A_MODE, 32'h1, "R2 set enable");
    bus_wr(A_MODE, 32'h0);
    bus_rd(A_MODE, 32'h1, "R2 enable not cleared");
    bus_wr(A_MODE, 32'hFFFF_FFF1);
    bus_rd(A_MODE, 32'h1, "R2 reserved zero");

    idle(40);
    bus_rd(A_CNT, 32'hFF, "R7 idle before feed");

    bus_wr(A_FEED, 32'hAA);
    bus_rd(A_MODE, 32'h1, "R6 interleaved read");
    bus_wr(A_FEED, 32'h55);
    bus_rd(A_CNT, 32'hFF, "R6 broken feed no reload");
    bus_wr(A_FEED, 32'hAA);
    bus_wr(A_FEED, 32'h12);
    bus_wr(A_FEED, 32'h55);
    bus_rd(A_CNT, 32'hFF, "R6 wrong key no reload");

    feed();
    bus_rd(A_CNT, 32'h1234, "R6 reload");
    bus_rd(A_CNT, 32'h1234, "R8 hold edge 1");
    idle(2);
    bus_rd(A_CNT, 32'h1233, "R8 first step edge 4");
    idle(3);
    bus_rd(A_CNT, 32'h1232, "R8 second step edge 8");

    // interrupt-only time-out, K = 0xFF
    bus_wr(A_CONST, 32'hFF);
    feed();
    idle(1024);
    check_pin(irq_o, 1'b0, "R4 no irq at edge 1023");
    idle(1);
    check_pin(irq_o, 1'b1, "R4 irq at edge 1024");
    check_pin(rst_req_o, 1'b0, "R9 no request without reset-enable");
    idle(2);
    check_pin(rst_req_o, 1'b0, "R9 still no request");
    bus_rd(A_MODE, 32'hC, "R4 flags set, enables cleared");
    bus_rd(A_CNT, 32'h0, "R4 count held at zero");
    idle(6);
    bus_rd(A_CNT, 32'h0, "R4 count stopped");

    bus_wr(A_MODE, 32'h0);
    bus_rd(A_MODE, 32'h8, "R3 tof cleared, int kept");
    check_pin(irq_o, 1'b1, "R3 irq follows int flag");

    // reset-enabled time-out
    bus_wr(A_MODE, 32'h3);
    bus_rd(A_MODE, 32'hB, "R2 set both");
    feed();
    idle(1024);
    check_pin(rst_req_o, 1'b0, "R9 no request at edge 1023");
    idle(1);
    check_pin(rst_req_o, 1'b1, "R9 request at edge 1024");
    idle(1);
    check_pin(rst_req_o, 1'b0, "R9 request one cycle");
    bus_rd(A_MODE, 32'hC, "R4 second time-out mode");

    bus_wr(A_CONST, 32'h400);
    bus_rd(A_CONST, 32'h400, "R5 const before wdt reset");
    @(posedge clk_i); #2;
    req_i = 1'b0; wdt_rst_i = 1'b1;
    @(posedge clk_i); #2;
    wdt_rst_i = 1'b0;
    bus_rd(A_MODE, 32'h4, "R10 only tof survives");
    bus_rd(A_CONST, 32'hFF, "R10 const back to min");
    bus_rd(A_CNT, 32'hFF, "R10 count back to min");
    idle(1);
    check_pin(irq_o, 1'b0, "R10 irq cleared");

    ext_reset();
    bus_rd(A_MODE, 32'h0, "R1 external reset clears tof");
    bus_wr(A_CONST, 32'h300);
    feed();
    idle(8);
    bus_rd(A_CNT, 32'hFF, "R7 feed ignored while disabled");

    idle(2);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule